// File: doc/BRIEF.md
# Nested Priority Interrupt Arbiter

This block sits between the interrupt sources of a small processor core and the core's trap logic. It watches 47 maskable request lines and one non-maskable line. Each maskable channel has its own enable bit, pending bit and 4-bit priority, all reachable through a narrow register write/read port. From the pending and enabled channels the block picks one winner and offers its number to the core. The core takes it with an acknowledge, and ends each handler with a return strobe.

Inside, the block keeps a two-entry stack of active handler priorities. A request may interrupt a running handler only when it is strictly more urgent, and only while fewer than two handlers are active. When a handler returns and a pending request would be allowed at the level left behind, the block hands that request straight over instead of popping. This is a tail-chain. It is reported with a one-cycle strobe and the chained number, and the nesting depth stays the same. Saving context, vector fetch and the pipeline are left to the core.

Top module: `irq_nest_arbiter`

## Requirements
- R1: After reset every enable, pending and priority field reads 0, `depth` is 0, and `takeValid` and `chainValid` are low.
- R2: Register port: `regSel` 0 selects the enable bit (data bit 0), 1 selects the pending bit (data bit 0, write sets or clears), 2 selects the priority (data bits 3:0). `regChan` 0..46 picks the channel. A write lands at the clock edge, and a read returns the stored value combinationally.
- R3: A high `irqReq[c]` at a clock edge sets pending bit c whether or not the channel is enabled. Only a channel that is both enabled and pending can be offered.
- R4: Among the enabled pending channels, the one with the smallest priority value wins. On equal values the lower channel number wins.
- R5: A pulse on `nmiReq` makes the block offer number 47. This ignores all enables and beats every maskable channel.
- R6: An acknowledge while `takeValid` is high clears the pending bit of the offered number and raises `depth` by one at that edge.
- R7: While a handler is active, a maskable request is offered only if its priority value is strictly below the active one. An equal value waits.
- R8: At `depth` 2 nothing is offered, not even the non-maskable request.
- R9: A return strobe at `depth` 1 or 2 with no eligible pending request lowers `depth` by one.
- R10: A return strobe with an eligible pending request keeps `depth` unchanged and clears that pending bit. On the next cycle it raises `chainValid` for one cycle, with the number on `chainId`. At `depth` 1 any pending winner is eligible.
- R11: At `depth` 2, a chained request must be strictly more urgent than the handler left underneath. Otherwise the return pops.
- R12: A return strobe at `depth` 0 has no effect. An acknowledge while nothing is offered has no effect.
- R13: While the non-maskable handler is active, neither a new non-maskable request nor any maskable request (even priority 0) is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| irqReq | input | 47 | Maskable request lines, one per channel |
| nmiReq | input | 1 | Non-maskable request |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 2 | Field select: 0 enable, 1 pending, 2 priority |
| regChan | input | 6 | Channel index for read and write |
| regWrData | input | 4 | Write data |
| regRdData | output | 4 | Read data of the selected field |
| takeValid | output | 1 | A request is offered to the core |
| takeId | output | 6 | Offered number (47 = non-maskable) |
| takeAck | input | 1 | Core takes the offered request |
| retStrobe | input | 1 | Core returns from the current handler |
| depth | output | 2 | Number of active handlers |
| chainValid | output | 1 | One-cycle strobe: a tail-chain was dispatched |
| chainId | output | 6 | Number that was tail-chained |

## Verification
A request pulse sets its pending bit at the edge that samples it, and the offer is combinational from the stored state. So `takeValid` and `takeId` are due in the cycle right after the pulse. An acknowledge or a return moves `depth` at its own edge. The chain strobe is registered, so it is visible in the cycle after the return and lasts exactly that cycle. The bench drives every input just after a falling edge and holds it across one rising edge. It then samples at the following falling edge, which is exactly when each of these results is due.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;

  typedef enum logic [1:0] {
    SEL_EN   = 2'd0,
    SEL_PEND = 2'd1,
    SEL_PRIO = 2'd2
  } regSel_e;

  // control -> datapath strobes
  typedef struct packed {
    logic clrWin;   // clear the pending state of the current winner
  } ctlStrobes_t;

endpackage

// File: rtl/irq_nest_datapath.sv
module irq_nest_datapath
  import irq_nest_pkg::*;
#(
  parameter int NUM_IRQ = 47,
  parameter int PRIO_W  = 4,
  parameter int ID_W    = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_IRQ-1:0] irqReq,
  input  logic               nmiReq,
  input  logic               regWrEn,
  input  logic [1:0]         regSel,
  input  logic [ID_W-1:0]    regChan,
  input  logic [PRIO_W-1:0]  regWrData,
  output logic [PRIO_W-1:0]  regRdData,
  input  ctlStrobes_t        strobes,
  output logic               winValid,
  output logic [ID_W-1:0]    winId,
  output logic [PRIO_W-1:0]  winPrio,
  output logic               winIsNmi
);

  localparam logic [ID_W-1:0] NMI_ID = ID_W'(NUM_IRQ);

  logic [NUM_IRQ-1:0] enVec;
  logic [NUM_IRQ-1:0] pendVec;
  logic [PRIO_W-1:0]  prioArr [NUM_IRQ];
  logic               nmiPendQ;

  logic               bestValid;
  logic [ID_W-1:0]    bestId;
  logic [PRIO_W-1:0]  bestPrio;

  // per-channel storage
  for (genvar c = 0; c < NUM_IRQ; c++) begin : g_chan
    logic              enR;
    logic              pendR;
    logic [PRIO_W-1:0] prioR;
    logic              hit;
    logic              clrHere;

    assign hit     = regWrEn && (regChan == ID_W'(c));
    assign clrHere = strobes.clrWin && !winIsNmi && (winId == ID_W'(c));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        enR   <= 1'b0;
        pendR <= 1'b0;
        prioR <= '0;
      end else begin
        if (hit && regSel == SEL_EN)   enR   <= regWrData[0];
        if (hit && regSel == SEL_PRIO) prioR <= regWrData;
        if (irqReq[c])                     pendR <= 1'b1;
        else if (hit && regSel == SEL_PEND) pendR <= regWrData[0];
        else if (clrHere)                  pendR <= 1'b0;
      end
    end

    assign enVec[c]   = enR;
    assign pendVec[c] = pendR;
    assign prioArr[c] = prioR;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                 nmiPendQ <= 1'b0;
    else if (nmiReq)                           nmiPendQ <= 1'b1;
    else if (strobes.clrWin && winIsNmi)       nmiPendQ <= 1'b0;
  end

  // lowest value wins, first (lowest) channel kept on ties
  always_comb begin
    bestValid = 1'b0;
    bestId    = '0;
    bestPrio  = '1;
    for (int c = 0; c < NUM_IRQ; c++) begin
      if (pendVec[c] && enVec[c] && (!bestValid || prioArr[c] < bestPrio)) begin
        bestValid = 1'b1;
        bestId    = ID_W'(c);
        bestPrio  = prioArr[c];
      end
    end
  end

  assign winIsNmi = nmiPendQ;
  assign winValid = nmiPendQ | bestValid;
  assign winId    = nmiPendQ ? NMI_ID : bestId;
  assign winPrio  = nmiPendQ ? '0 : bestPrio;

  always_comb begin
    regRdData = '0;
    for (int c = 0; c < NUM_IRQ; c++) begin
      if (regChan == ID_W'(c)) begin
        unique case (regSel)
          SEL_EN:   regRdData = {{(PRIO_W-1){1'b0}}, enVec[c]};
          SEL_PEND: regRdData = {{(PRIO_W-1){1'b0}}, pendVec[c]};
          SEL_PRIO: regRdData = prioArr[c];
          default:  regRdData = '0;
        endcase
      end
    end
  end

endmodule

// File: rtl/irq_nest_control.sv
module irq_nest_control
  import irq_nest_pkg::*;
#(
  parameter int PRIO_W   = 4,
  parameter int ID_W     = 6,
  parameter int MAX_NEST = 2,
  parameter int DEPTH_W  = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               takeAck,
  input  logic               retStrobe,
  input  logic               winValid,
  input  logic [ID_W-1:0]    winId,
  input  logic [PRIO_W-1:0]  winPrio,
  input  logic               winIsNmi,
  output ctlStrobes_t        strobes,
  output logic               takeValid,
  output logic [DEPTH_W-1:0] depth,
  output logic               chainValid,
  output logic [ID_W-1:0]    chainId
);

  logic [PRIO_W-1:0]  stPrio [MAX_NEST];
  logic               stNmi  [MAX_NEST];
  logic [DEPTH_W-1:0] depthQ;

  logic [PRIO_W-1:0]  topPrio, undPrio;
  logic               topNmi, undNmi;
  logic               takeOk, doRet, chainOk, doAck;

  always_comb begin
    topPrio = '0;
    topNmi  = 1'b0;
    undPrio = '0;
    undNmi  = 1'b0;
    for (int i = 0; i < MAX_NEST; i++) begin
      if (i == int'(depthQ) - 1) begin
        topPrio = stPrio[i];
        topNmi  = stNmi[i];
      end
      if (i == int'(depthQ) - 2) begin
        undPrio = stPrio[i];
        undNmi  = stNmi[i];
      end
    end
  end

  function automatic logic beats(input logic candNmi, input logic [PRIO_W-1:0] candPrio,
                                 input logic entNmi,  input logic [PRIO_W-1:0] entPrio);
    return candNmi ? !entNmi : (!entNmi && (candPrio < entPrio));
  endfunction

  assign takeOk  = winValid && (int'(depthQ) < MAX_NEST) &&
                   ((depthQ == '0) || beats(winIsNmi, winPrio, topNmi, topPrio));
  assign doRet   = retStrobe && (depthQ != '0);
  assign chainOk = doRet && winValid &&
                   ((depthQ == DEPTH_W'(1)) || beats(winIsNmi, winPrio, undNmi, undPrio));
  assign doAck   = takeAck && takeOk && !retStrobe;

  always_comb begin
    strobes        = '0;
    strobes.clrWin = doAck || chainOk;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      depthQ     <= '0;
      chainValid <= 1'b0;
      chainId    <= '0;
      for (int i = 0; i < MAX_NEST; i++) begin
        stPrio[i] <= '0;
        stNmi[i]  <= 1'b0;
      end
    end else begin
      chainValid <= chainOk;
      if (chainOk) chainId <= winId;
      for (int i = 0; i < MAX_NEST; i++) begin
        if (chainOk && i == int'(depthQ) - 1) begin
          stPrio[i] <= winPrio;
          stNmi[i]  <= winIsNmi;
        end else if (doAck && i == int'(depthQ)) begin
          stPrio[i] <= winPrio;
          stNmi[i]  <= winIsNmi;
        end
      end
      if (chainOk)    depthQ <= depthQ;
      else if (doRet) depthQ <= depthQ - DEPTH_W'(1);
      else if (doAck) depthQ <= depthQ + DEPTH_W'(1);
    end
  end

  assign takeValid = takeOk;
  assign depth     = depthQ;

endmodule

// File: rtl/irq_nest_arbiter.sv
module irq_nest_arbiter
  import irq_nest_pkg::*;
#(
  parameter int NUM_IRQ  = 47,
  parameter int PRIO_W   = 4,
  parameter int MAX_NEST = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_IRQ-1:0] irqReq,
  input  logic               nmiReq,
  input  logic               regWrEn,
  input  logic [1:0]         regSel,
  input  logic [5:0]         regChan,
  input  logic [PRIO_W-1:0]  regWrData,
  output logic [PRIO_W-1:0]  regRdData,
  output logic               takeValid,
  output logic [5:0]         takeId,
  input  logic               takeAck,
  input  logic               retStrobe,
  output logic [1:0]         depth,
  output logic               chainValid,
  output logic [5:0]         chainId
);

  localparam int ID_W    = $clog2(NUM_IRQ + 1);
  localparam int DEPTH_W = $clog2(MAX_NEST + 1);

  ctlStrobes_t       strobes;
  logic              winValid, winIsNmi;
  logic [ID_W-1:0]   winId;
  logic [PRIO_W-1:0] winPrio;

  irq_nest_datapath #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W), .ID_W(ID_W)) dp_i (
    .clk(clk), .rstN(rstN), .irqReq(irqReq), .nmiReq(nmiReq),
    .regWrEn(regWrEn), .regSel(regSel), .regChan(regChan),
    .regWrData(regWrData), .regRdData(regRdData), .strobes(strobes),
    .winValid(winValid), .winId(winId), .winPrio(winPrio), .winIsNmi(winIsNmi)
  );

  irq_nest_control #(.PRIO_W(PRIO_W), .ID_W(ID_W), .MAX_NEST(MAX_NEST), .DEPTH_W(DEPTH_W)) ctl_i (
    .clk(clk), .rstN(rstN), .takeAck(takeAck), .retStrobe(retStrobe),
    .winValid(winValid), .winId(winId), .winPrio(winPrio), .winIsNmi(winIsNmi),
    .strobes(strobes), .takeValid(takeValid), .depth(depth),
    .chainValid(chainValid), .chainId(chainId)
  );

  assign takeId = winId;

endmodule

// File: rtl/irq_nest_checker.sv
module irq_nest_checker #(
  parameter int MAX_NEST = 2
) (
  input logic       clk,
  input logic       rstN,
  input logic       takeValid,
  input logic       takeAck,
  input logic       retStrobe,
  input logic       chainValid,
  input logic [1:0] depth
);

  AST_DEPTH_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    int'(depth) <= MAX_NEST); // R8

  AST_FULL_NO_OFFER: assert property (@(posedge clk) disable iff (!rstN)
    int'(depth) == MAX_NEST |-> !takeValid); // R8

  AST_ACK_PUSH: assert property (@(posedge clk) disable iff (!rstN)
    takeAck && takeValid && !retStrobe |=> depth == $past(depth) + 2'd1); // R6

  AST_RET_POP_OR_CHAIN: assert property (@(posedge clk) disable iff (!rstN)
    retStrobe && depth != 2'd0 |=>
      (chainValid && depth == $past(depth)) || (!chainValid && depth == $past(depth) - 2'd1)); // R9

  AST_CHAIN_AFTER_RET: assert property (@(posedge clk) disable iff (!rstN)
    chainValid |-> $past(retStrobe)); // R10

  AST_IDLE_RET: assert property (@(posedge clk) disable iff (!rstN)
    retStrobe && depth == 2'd0 |=> depth == 2'd0 && !chainValid); // R12

endmodule

bind irq_nest_arbiter irq_nest_checker #(.MAX_NEST(MAX_NEST)) chk_i (
  .clk(clk), .rstN(rstN), .takeValid(takeValid), .takeAck(takeAck),
  .retStrobe(retStrobe), .chainValid(chainValid), .depth(depth)
);

// File: tb/irq_nest_arbiter_tb_top.sv
module irq_nest_arbiter_tb_top;

  localparam int NUM_IRQ = 47;
  localparam int NMI_NUM = 47;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic [NUM_IRQ-1:0] irqReq = '0;
  logic               nmiReq = 1'b0;
  logic               regWrEn = 1'b0;
  logic [1:0]         regSel = 2'd0;
  logic [5:0]         regChan = 6'd0;
  logic [3:0]         regWrData = 4'd0;
  logic [3:0]         regRdData;
  logic               takeValid;
  logic [5:0]         takeId;
  logic               takeAck = 1'b0;
  logic               retStrobe = 1'b0;
  logic [1:0]         depth;
  logic               chainValid;
  logic [5:0]         chainId;

  int testsRun = 0;
  int testsFailed = 0;

  always #2 clk = ~clk;

  irq_nest_arbiter dut_i (
    .clk(clk), .rstN(rstN), .irqReq(irqReq), .nmiReq(nmiReq),
    .regWrEn(regWrEn), .regSel(regSel), .regChan(regChan),
    .regWrData(regWrData), .regRdData(regRdData),
    .takeValid(takeValid), .takeId(takeId), .takeAck(takeAck),
    .retStrobe(retStrobe), .depth(depth), .chainValid(chainValid), .chainId(chainId)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wrReg(input int sel, input int chan, input int data);
    regWrEn = 1'b1; regSel = 2'(sel); regChan = 6'(chan); regWrData = 4'(data);
    cycle();
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(input int sel, input int chan, output int data);
    regSel = 2'(sel); regChan = 6'(chan);
    #1;
    data = int'(regRdData);
  endtask

  task automatic setupChan(input int chan, input int prio);
    wrReg(2, chan, prio);
    wrReg(0, chan, 1);
  endtask

  task automatic pulseIrq(input int chan);
    irqReq[chan] = 1'b1;
    cycle();
    irqReq = '0;
  endtask

  task automatic pulseNmi();
    nmiReq = 1'b1;
    cycle();
    nmiReq = 1'b0;
  endtask

  task automatic doAck();
    takeAck = 1'b1;
    cycle();
    takeAck = 1'b0;
  endtask

  task automatic doRet();
    retStrobe = 1'b1;
    cycle();
    retStrobe = 1'b0;
  endtask

  task automatic t_reset();
    int v;
    check("R1", "takeValid", int'(takeValid), 0);
    check("R1", "depth", int'(depth), 0);
    check("R1", "chainValid", int'(chainValid), 0);
    rdReg(0, 5, v);  check("R1", "enable ch5", v, 0);
    rdReg(1, 0, v);  check("R1", "pending ch0", v, 0);
    rdReg(2, 46, v); check("R1", "prio ch46", v, 0);
  endtask

  task automatic t_regs();
    int v;
    wrReg(2, 3, 9);  rdReg(2, 3, v); check("R2", "prio ch3", v, 9);
    wrReg(0, 3, 1);  rdReg(0, 3, v); check("R2", "enable ch3", v, 1);
    wrReg(1, 3, 1);  rdReg(1, 3, v); check("R2", "sw pending set", v, 1);
    check("R2", "offer after sw set", int'(takeValid), 1);
    check("R2", "offer id", int'(takeId), 3);
    wrReg(1, 3, 0);  rdReg(1, 3, v); check("R2", "sw pending clear", v, 0);
    check("R2", "no offer after clear", int'(takeValid), 0);
  endtask

  task automatic t_pend_mask();
    int v;
    wrReg(2, 10, 6);
    pulseIrq(10);
    rdReg(1, 10, v); check("R3", "pending on disabled", v, 1);
    check("R3", "disabled not offered", int'(takeValid), 0);
    wrReg(0, 10, 1);
    check("R3", "offered once enabled", int'(takeValid), 1);
    check("R3", "offered id", int'(takeId), 10);
    wrReg(1, 10, 0);
  endtask

  task automatic t_arb();
    setupChan(7, 5); setupChan(20, 3); setupChan(30, 3);
    irqReq[7] = 1'b1; irqReq[20] = 1'b1; irqReq[30] = 1'b1;
    cycle();
    irqReq = '0;
    check("R4", "lowest value, lowest channel", int'(takeId), 20);
    wrReg(1, 20, 0);
    check("R4", "tie gone, next lowest", int'(takeId), 30);
    wrReg(1, 30, 0);
    check("R4", "remaining", int'(takeId), 7);
    wrReg(1, 7, 0);
    check("R4", "none left", int'(takeValid), 0);
  endtask

  task automatic t_nmi();
    int v;
    wrReg(2, 20, 0);
    pulseIrq(20);
    pulseNmi();
    check("R5", "nmi offered", int'(takeValid), 1);
    check("R5", "nmi id beats prio0", int'(takeId), NMI_NUM);
    doAck();
    check("R6", "depth after nmi ack", int'(depth), 1);
    check("R13", "prio0 blocked under nmi", int'(takeValid), 0);
    pulseNmi();
    check("R13", "second nmi blocked", int'(takeValid), 0);
    doRet();
    check("R10", "chain nmi strobe", int'(chainValid), 1);
    check("R10", "chain nmi id", int'(chainId), NMI_NUM);
    check("R10", "chain keeps depth", int'(depth), 1);
    doRet();
    check("R10", "chain ch20 id", int'(chainId), 20);
    rdReg(1, 20, v); check("R10", "chained pending cleared", v, 0);
    doRet();
    check("R9", "pop to idle", int'(depth), 0);
    check("R9", "no chain strobe", int'(chainValid), 0);
  endtask

  task automatic t_preempt();
    int v;
    setupChan(4, 8); setupChan(5, 8); setupChan(6, 2); setupChan(9, 0);
    pulseIrq(4);
    doAck();
    check("R6", "depth 1", int'(depth), 1);
    rdReg(1, 4, v); check("R6", "acked pending cleared", v, 0);
    pulseIrq(5);
    check("R7", "equal priority waits", int'(takeValid), 0);
    pulseIrq(6);
    check("R7", "higher preempts", int'(takeValid), 1);
    check("R7", "preempt id", int'(takeId), 6);
    doAck();
    check("R6", "depth 2", int'(depth), 2);
    pulseIrq(9);
    check("R8", "third level blocked", int'(takeValid), 0);
    pulseNmi();
    check("R8", "nmi blocked at depth 2", int'(takeValid), 0);
    doRet();
    check("R11", "nmi chains at depth 2", int'(chainId), NMI_NUM);
    check("R11", "depth kept", int'(depth), 2);
    doRet();
    check("R11", "prio0 chains over prio8", int'(chainId), 9);
    doRet();
    check("R11", "equal under entry pops", int'(depth), 1);
    check("R11", "no chain strobe", int'(chainValid), 0);
    doRet();
    check("R10", "depth1 chains any", int'(chainValid), 1);
    check("R10", "chain id ch5", int'(chainId), 5);
    doRet();
    check("R9", "back to idle", int'(depth), 0);
  endtask

  task automatic t_idle();
    doRet();
    check("R12", "ret at idle depth", int'(depth), 0);
    check("R12", "ret at idle no chain", int'(chainValid), 0);
    doAck();
    check("R12", "stray ack depth", int'(depth), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_pend_mask();
    t_arb();
    t_nmi();
    t_preempt();
    t_idle();
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    testsRun++;
    testsFailed++;
    $display("FAIL R1 watchdog: actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule